// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flags

This block is the combinational arithmetic and logic unit of a small accumulator-based controller. Each evaluation takes the accumulator value, a second operand, the current carry and nibble (auxiliary) carry flags and a 5-bit operation code. It returns an 8-bit result, new carry, auxiliary-carry and overflow values, a 3-bit mask naming the flags the operation writes, and an inequality indication for compare-and-branch use.

The surrounding datapath writes the result wherever the instruction targets and uses the mask to update only the flags the operation owns. The outputs of flags that are not written repeat the incoming values, so a datapath that ignores the mask still sees unchanged flags. Overflow has no input, so it reads 0 when not written. There is no clock and no state: every output depends only on the present inputs.

Top module: `alu8_core`

## Requirements
- R1: Add (op 0) computes a+b and add-with-carry (op 1) computes a+b+cy_i. For both, cy_o is the carry out of bit 7 and ac_o is the carry out of bit 3, each 0 when there is no such carry. Example: 0xC3+0xAA gives 0x6D with cy_o=1 and ac_o=0.
- R2: For ops 0, 1 and 2, ov_o is the carry (or borrow) into bit 7 XOR the carry (or borrow) out of bit 7. Example: 0xC3+0xAA gives ov_o=1, and 0xC3+0xAA+1 gives 0x6E with cy_o=1, ac_o=0, ov_o=1.
- R3: Subtract-with-borrow (op 2) computes a-b-cy_i. cy_o is set on a borrow out of bit 7 and ac_o on a borrow out of bit 3.
- R4: AND (op 3), OR (op 4) and XOR (op 5) give the bitwise result, write no flag (mask 000), and pass cy_i and ac_i through.
- R5: Increment (op 6) wraps 0xFF to 0x00 and decrement (op 7) wraps 0x00 to 0xFF. Neither writes a flag.
- R6: Clear (op 8) gives 0x00, complement (op 9) gives ~a and swap (op 14) exchanges the nibbles of a. None of them writes a flag.
- R7: Rotate left (op 10) and rotate right (op 11) rotate a by one bit and write no flag.
- R8: Rotate left through carry (op 12) gives {a[6:0],cy_i} with cy_o=a[7]. Rotate right through carry (op 13) gives {cy_i,a[7:1]} with cy_o=a[0]. Both write carry only (mask 100).
- R9: Decimal adjust (op 15), first step: 6 is added to a when a[3:0]>9 or ac_i=1, and a carry out of bit 7 from this addition sets the carry.
- R10: Decimal adjust, second step: 0x60 is added when the carry after the first step is set or the upper nibble exceeds 9. Carry is never cleared by the op, and only carry is written (mask 100). Example: 0xBE with both flags clear gives 0x24 with cy_o=1.
- R11: Compare (op 16) returns a unchanged and sets cy_o=1 exactly when a<b as unsigned values. It writes carry only. For every op, neq_o is 1 exactly when a!=b.
- R12: wmask_o bit 2 marks carry, bit 1 auxiliary carry and bit 0 overflow. Ops 0 to 2 give 111. Unwritten cy_o and ac_o repeat cy_i and ac_i, and unwritten ov_o is 0. Codes 17 to 31 return a with mask 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Second operand |
| cy_i | input | 1 | Incoming carry flag |
| ac_i | input | 1 | Incoming auxiliary (nibble) carry flag |
| op_i | input | 5 | Operation code |
| res_o | output | 8 | Result byte |
| cy_o | output | 1 | Carry flag out |
| ac_o | output | 1 | Auxiliary carry flag out |
| ov_o | output | 1 | Overflow flag out |
| wmask_o | output | 3 | Flags written: {carry, aux carry, overflow} |
| neq_o | output | 1 | Operands differ |

## Verification
Decimal adjust can apply its low-nibble and high-nibble corrections in the same evaluation, and the carry from the first correction must feed the decision for the second. The bench provokes this with accumulator values whose low nibble exceeds 9 and whose upper nibble is 9 or above, such as 0xBE and 0x9A, together with cases where only one step or no step fires and cases where carry enters already set. Each result and the sticky carry are judged against a model that applies the two rules in order.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;
    localparam int OP_W   = 5;
    localparam int FLAG_N = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 5'd0,  OP_ADDC = 5'd1,  OP_SUBB = 5'd2,
        OP_AND  = 5'd3,  OP_OR   = 5'd4,  OP_XOR  = 5'd5,
        OP_INC  = 5'd6,  OP_DEC  = 5'd7,  OP_CLR  = 5'd8,
        OP_CPL  = 5'd9,  OP_RL   = 5'd10, OP_RR   = 5'd11,
        OP_RLC  = 5'd12, OP_RRC  = 5'd13, OP_SWAP = 5'd14,
        OP_DA   = 5'd15, OP_CMP  = 5'd16
    } alu_op_e;

    typedef struct packed {
        logic cy;
        logic ac;
        logic ov;
    } flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        flags_t            flg;
    } unit_out_t;

    localparam logic [FLAG_N-1:0] MASK_ALL  = 3'b111;
    localparam logic [FLAG_N-1:0] MASK_CY   = 3'b100;
    localparam logic [FLAG_N-1:0] MASK_NONE = 3'b000;

    function automatic logic nib_over9(input logic [NIB_W-1:0] n);
        return n > NIB_W'(9);
    endfunction
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub
    import alu8_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              sub_i,
    output unit_out_t         out_o
);
    logic [DATA_W:0] full;
    logic            c_msb_in;

    always_comb begin
        if (sub_i)
            full = {1'b0, a_i} - {1'b0, b_i} - {{DATA_W{1'b0}}, cin_i};
        else
            full = {1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i};
        // carry or borrow entering a bit position: operand bits xor sum bit
        c_msb_in   = a_i[DATA_W-1] ^ b_i[DATA_W-1] ^ full[DATA_W-1];
        out_o.res  = full[DATA_W-1:0];
        out_o.flg.cy = full[DATA_W];
        out_o.flg.ac = a_i[NIB_W] ^ b_i[NIB_W] ^ full[NIB_W];
        out_o.flg.ov = full[DATA_W] ^ c_msb_in;
    end
endmodule

// File: rtl/alu8_shiftlog.sv
module alu8_shiftlog
    import alu8_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cy_i,
    input  alu_op_e           op_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cy_o
);
    always_comb begin
        cy_o  = cy_i;
        res_o = a_i;
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            OP_INC:  res_o = a_i + DATA_W'(1);
            OP_DEC:  res_o = a_i - DATA_W'(1);
            OP_CLR:  res_o = '0;
            OP_CPL:  res_o = ~a_i;
            OP_RL:   res_o = {a_i[DATA_W-2:0], a_i[DATA_W-1]};
            OP_RR:   res_o = {a_i[0], a_i[DATA_W-1:1]};
            OP_RLC: begin
                res_o = {a_i[DATA_W-2:0], cy_i};
                cy_o  = a_i[DATA_W-1];
            end
            OP_RRC: begin
                res_o = {cy_i, a_i[DATA_W-1:1]};
                cy_o  = a_i[0];
            end
            OP_SWAP: res_o = {a_i[NIB_W-1:0], a_i[DATA_W-1:NIB_W]};
            default: res_o = a_i;
        endcase
    end
endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj
    import alu8_pkg::*;
(
    input  logic [DATA_W-1:0] a_i,
    input  logic              cy_i,
    input  logic              ac_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cy_o
);
    logic [DATA_W:0] step1;
    logic [DATA_W:0] step2;
    logic            cy_mid;
    logic            fix_lo;
    logic            fix_hi;

    always_comb begin
        fix_lo = nib_over9(a_i[NIB_W-1:0]) || ac_i;
        step1  = {1'b0, a_i} + (fix_lo ? (DATA_W+1)'(6) : '0);
        cy_mid = cy_i | step1[DATA_W];
        fix_hi = cy_mid || nib_over9(step1[DATA_W-1:NIB_W]);
        step2  = {1'b0, step1[DATA_W-1:0]} + (fix_hi ? (DATA_W+1)'(8'h60) : '0);
        cy_o   = cy_mid | step2[DATA_W];
        res_o  = step2[DATA_W-1:0];
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [7:0] a_i,
    input  logic [7:0] b_i,
    input  logic       cy_i,
    input  logic       ac_i,
    input  logic [4:0] op_i,
    output logic [7:0] res_o,
    output logic       cy_o,
    output logic       ac_o,
    output logic       ov_o,
    output logic [2:0] wmask_o,
    output logic       neq_o
);
    alu_op_e           op;
    unit_out_t         as_out;
    unit_out_t         cmp_out;
    logic [DATA_W-1:0] sl_res;
    logic              sl_cy;
    logic [DATA_W-1:0] da_res;
    logic              da_cy;

    assign op = alu_op_e'(op_i);

    alu8_addsub u_arith (
        .a_i   (a_i),
        .b_i   (b_i),
        .cin_i ((op == OP_ADDC || op == OP_SUBB) ? cy_i : 1'b0),
        .sub_i (op == OP_SUBB),
        .out_o (as_out)
    );

    // compare: a borrow out of a-b means a < b unsigned
    alu8_addsub u_cmp (
        .a_i   (a_i),
        .b_i   (b_i),
        .cin_i (1'b0),
        .sub_i (1'b1),
        .out_o (cmp_out)
    );

    alu8_shiftlog u_shl (
        .a_i   (a_i),
        .b_i   (b_i),
        .cy_i  (cy_i),
        .op_i  (op),
        .res_o (sl_res),
        .cy_o  (sl_cy)
    );

    alu8_decadj u_da (
        .a_i   (a_i),
        .cy_i  (cy_i),
        .ac_i  (ac_i),
        .res_o (da_res),
        .cy_o  (da_cy)
    );

    always_comb begin
        res_o   = a_i;
        cy_o    = cy_i;
        ac_o    = ac_i;
        ov_o    = 1'b0;
        wmask_o = MASK_NONE;
        case (op)
            OP_ADD, OP_ADDC, OP_SUBB: begin
                res_o   = as_out.res;
                cy_o    = as_out.flg.cy;
                ac_o    = as_out.flg.ac;
                ov_o    = as_out.flg.ov;
                wmask_o = MASK_ALL;
            end
            OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC, OP_CLR,
            OP_CPL, OP_RL, OP_RR, OP_SWAP: begin
                res_o = sl_res;
            end
            OP_RLC, OP_RRC: begin
                res_o   = sl_res;
                cy_o    = sl_cy;
                wmask_o = MASK_CY;
            end
            OP_DA: begin
                res_o   = da_res;
                cy_o    = da_cy;
                wmask_o = MASK_CY;
            end
            OP_CMP: begin
                cy_o    = cmp_out.flg.cy;
                wmask_o = MASK_CY;
            end
            default: ;
        endcase
        neq_o = |cmp_out.res;
    end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk (
    input logic [7:0] a_i,
    input logic [7:0] b_i,
    input logic       cy_i,
    input logic       ac_i,
    input logic [4:0] op_i,
    input logic [7:0] res_o,
    input logic       cy_o,
    input logic       ac_o,
    input logic       ov_o,
    input logic [2:0] wmask_o,
    input logic       neq_o
);
    always_comb begin
        if (op_i == 5'd0) begin
            p_add_ov_r2: assert (ov_o == ((a_i[7] == b_i[7]) && (res_o[7] != a_i[7])))
                else $error("add overflow mismatch");
        end
        if (op_i == 5'd3 || op_i == 5'd4 || op_i == 5'd5) begin
            p_logic_noflag_r4: assert (wmask_o == 3'b000 && cy_o == cy_i && ac_o == ac_i)
                else $error("logic op touched flags");
        end
        if (op_i == 5'd10) begin
            p_rl_keeps_cy_r7: assert (res_o == {a_i[6:0], a_i[7]} && cy_o == cy_i)
                else $error("rotate left mismatch");
        end
        if (op_i == 5'd15 && cy_i) begin
            p_da_sticky_r10: assert (cy_o && wmask_o == 3'b100)
                else $error("decimal adjust cleared carry");
        end
        if (op_i == 5'd16) begin
            p_cmp_r11: assert (res_o == a_i && cy_o == (a_i < b_i) && wmask_o == 3'b100)
                else $error("compare mismatch");
        end
        p_neq_r11: assert (neq_o == (a_i != b_i))
            else $error("inequality output mismatch");
    end
endmodule

bind alu8_core alu8_core_chk u_chk (.*);

// File: tb/alu8_core_tb.sv
`timescale 1ns/1ps
module alu8_core_tb;
    typedef struct {
        logic [7:0] res;
        logic       cy;
        logic       ac;
        logic       ov;
        logic [2:0] mask;
        logic       neq;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] a_i = '0;
    logic [7:0] b_i = '0;
    logic       cy_i = 1'b0;
    logic       ac_i = 1'b0;
    logic [4:0] op_i = '0;
    logic [7:0] res_o;
    logic       cy_o, ac_o, ov_o, neq_o;
    logic [2:0] wmask_o;

    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 0;
    exp_t sb[$];

    always #4 clk = ~clk;

    alu8_core u_dut (
        .a_i(a_i), .b_i(b_i), .cy_i(cy_i), .ac_i(ac_i), .op_i(op_i),
        .res_o(res_o), .cy_o(cy_o), .ac_o(ac_o), .ov_o(ov_o),
        .wmask_o(wmask_o), .neq_o(neq_o)
    );

    function automatic exp_t model(input int op, input int a, input int b,
                                   input int c, input int h, input string tag);
        exp_t e;
        int s, sa, sb2, lo, hi, v;
        e.res = a[7:0]; e.cy = c[0]; e.ac = h[0]; e.ov = 0; e.mask = 3'b000;
        e.neq = (a != b); e.tag = tag;
        sa  = (a > 127) ? a - 256 : a;
        sb2 = (b > 127) ? b - 256 : b;
        case (op)
            0, 1: begin
                if (op == 0) c = 0;
                s = a + b + c;
                e.res = s[7:0]; e.cy = (s > 255);
                e.ac = ((a % 16) + (b % 16) + c) > 15;
                e.ov = (sa + sb2 + c > 127) || (sa + sb2 + c < -128);
                e.mask = 3'b111;
            end
            2: begin
                s = a - b - c;
                e.res = s[7:0]; e.cy = (s < 0);
                e.ac = ((a % 16) - (b % 16) - c) < 0;
                e.ov = (sa - sb2 - c > 127) || (sa - sb2 - c < -128);
                e.mask = 3'b111;
            end
            3: e.res = a[7:0] & b[7:0];
            4: e.res = a[7:0] | b[7:0];
            5: e.res = a[7:0] ^ b[7:0];
            6: begin v = (a + 1) % 256; e.res = v[7:0]; end
            7: begin v = (a + 255) % 256; e.res = v[7:0]; end
            8: e.res = 8'h00;
            9: e.res = ~a[7:0];
            10: begin v = (a * 2) % 256 + a / 128; e.res = v[7:0]; end
            11: begin v = a / 2 + (a % 2) * 128; e.res = v[7:0]; end
            12: begin v = (a * 2) % 256 + c; e.res = v[7:0]; e.cy = (a >= 128); e.mask = 3'b100; end
            13: begin v = a / 2 + c * 128; e.res = v[7:0]; e.cy = a[0]; e.mask = 3'b100; end
            14: begin v = (a % 16) * 16 + a / 16; e.res = v[7:0]; end
            15: begin
                v = a;
                if ((v % 16) > 9 || h == 1) begin v = v + 6; if (v > 255) c = 1; v = v % 256; end
                if (c == 1 || (v / 16) > 9) begin v = v + 96; if (v > 255) c = 1; v = v % 256; end
                e.res = v[7:0]; e.cy = c[0]; e.mask = 3'b100;
            end
            16: begin e.cy = (a < b); e.mask = 3'b100; end
            default: ;
        endcase
        return e;
    endfunction

    task automatic drive(input int op, input int a, input int b,
                         input int c, input int h, input string tag);
        @(posedge clk);
        #1;
        op_i = op[4:0]; a_i = a[7:0]; b_i = b[7:0]; cy_i = c[0]; ac_i = h[0];
        sb.push_back(model(op, a, b, c, h, tag));
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (res_o !== e.res || cy_o !== e.cy || ac_o !== e.ac || ov_o !== e.ov ||
                wmask_o !== e.mask || neq_o !== e.neq) begin
                n_errors++;
                $display("FAIL %s: got res=%h cy=%b ac=%b ov=%b mask=%b neq=%b exp res=%h cy=%b ac=%b ov=%b mask=%b neq=%b",
                         e.tag, res_o, cy_o, ac_o, ov_o, wmask_o, neq_o,
                         e.res, e.cy, e.ac, e.ov, e.mask, e.neq);
            end
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_errors++; n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        drive(8, 8'h00, 8'h00, 0, 0, "R12 idle clear");
        drive(0, 8'hC3, 8'hAA, 0, 0, "R1 R2 add example");
        drive(1, 8'hC3, 8'hAA, 1, 0, "R1 R2 addc example");
        drive(0, 8'h0F, 8'h01, 1, 0, "R1 add nibble carry ignores cy_i");
        drive(0, 8'h7F, 8'h01, 0, 1, "R2 add positive overflow");
        drive(1, 8'h56, 8'h67, 1, 1, "R1 addc bcd sum");
        drive(2, 8'h10, 8'h01, 0, 0, "R3 subb nibble borrow");
        drive(2, 8'h00, 8'h00, 1, 0, "R3 subb borrow from carry");
        drive(2, 8'h80, 8'h01, 0, 0, "R2 R3 subb overflow");
        drive(2, 8'h55, 8'h22, 0, 1, "R3 subb clean");
        drive(3, 8'hC3, 8'h55, 1, 1, "R4 and");
        drive(4, 8'hA0, 8'h05, 0, 1, "R4 or");
        drive(5, 8'hFF, 8'h0F, 1, 0, "R4 xor");
        drive(6, 8'hFF, 8'h00, 0, 0, "R5 inc wrap");
        drive(7, 8'h00, 8'h00, 1, 1, "R5 dec wrap");
        drive(8, 8'h5C, 8'h00, 1, 0, "R6 clr");
        drive(9, 8'h5C, 8'h00, 0, 1, "R6 cpl");
        drive(14, 8'h3A, 8'h00, 1, 1, "R6 swap");
        drive(10, 8'h81, 8'h00, 0, 0, "R7 rl");
        drive(11, 8'h01, 8'h00, 1, 0, "R7 rr");
        drive(12, 8'h80, 8'h00, 0, 0, "R8 rlc out");
        drive(12, 8'h01, 8'h00, 1, 1, "R8 rlc in");
        drive(13, 8'h01, 8'h00, 0, 0, "R8 rrc out");
        drive(13, 8'h80, 8'h00, 1, 0, "R8 rrc in");
        drive(15, 8'hBE, 8'h00, 0, 0, "R9 R10 da both steps");
        drive(15, 8'hC9, 8'h00, 0, 0, "R10 da high only");
        drive(15, 8'h9A, 8'h00, 0, 0, "R9 R10 da low feeds high");
        drive(15, 8'h12, 8'h00, 0, 1, "R9 da aux only");
        drive(15, 8'h12, 8'h00, 1, 0, "R10 da sticky carry");
        drive(15, 8'h45, 8'h00, 0, 0, "R9 da none");
        drive(15, 8'hFA, 8'h00, 0, 0, "R9 da low step overflow");
        drive(16, 8'h34, 8'h56, 0, 0, "R11 cmp less");
        drive(16, 8'h56, 8'h34, 1, 0, "R11 cmp greater");
        drive(16, 8'h34, 8'h34, 1, 1, "R11 cmp equal");
        drive(16, 8'h01, 8'hFF, 0, 0, "R11 cmp unsigned");
        drive(20, 8'h77, 8'h01, 1, 1, "R12 unused code");
        drive(31, 8'h00, 8'h00, 0, 0, "R12 top code");
        @(posedge clk);
        @(posedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule